// File: doc/BRIEF.md
# Priority Address Window Translator

This block sits on the outbound path of a bus bridge. It takes a 32-bit address from the local bus and checks it against three programmable windows. When a window claims the address, the block produces a translated address for the far-side bus, a cycle type, a prefetchable flag and the index of the window that claimed it. Issuing the bus cycle that follows is handled elsewhere.

Two of the windows are memory windows with a programmable power-of-two size, from 1 MB up to 2 GB. The third is a fixed 16 MB I/O window. Each window has a base register and a map register, both loaded through a simple write port. Windows may overlap. The lowest-numbered enabled window that matches always wins, so software can enlarge window 0 to hide window 1 while it reprograms window 1 for some other use. The translation is purely combinational from the address and the register contents.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every register is zero, so all windows are disabled, `hit` is 0 and `out_addr`, `win_idx`, `cyc_type` and `pref` are all 0.
- R2: The write port selects a register with `wr_sel`: 0 is memory base 0, 1 is map 0, 2 is memory base 1, 3 is map 1, 4 is the I/O base and 5 is the I/O map. Map registers keep `wr_data[15:0]`. A write changes the outputs starting at the clock edge on which `wr_en` is sampled high. Selects 6 and 7 change nothing.
- R3: In a memory window, base bit 0 enables the window and bits 7..4 hold the size code c, giving a size of 2^(20+c) bytes. The window matches when address bits 31..(20+c) equal the same bits of the base register.
- R4: A memory window whose size code is greater than 11 never matches.
- R5: A memory-window hit takes output bits 31..(20+c) from map bits 15..4, where map bit 15 gives address bit 31 and map bit 4 gives address bit 20. Output bits below 20+c are copied from the local address, except bits 1..0, which follow R7.
- R6: A memory-window hit drives `cyc_type` from map bits 3..1 and `pref` from base bit 3. The cycle type codes are 0 interrupt acknowledge, 1 I/O, 3 memory, 5 configuration and 6 memory read multiple.
- R7: On a memory-window hit, map bit 0 set copies address bits 1..0 to the output. Map bit 0 clear forces output bits 1..0 to zero.
- R8: The I/O window is enabled by its base bit 0 and matches when address bits 31..24 equal base bits 15..8. On a hit, output bits 31..24 come from map bits 15..8, bits 23..0 are copied from the address, `cyc_type` is 1 and `pref` is 0.
- R9: When several enabled windows match, the lowest-numbered one is reported. `win_idx` is 0 or 1 for the memory windows and 2 for the I/O window.
- R10: An address that no enabled window matches gives `hit` 0, and `win_idx`, `out_addr`, `cyc_type` and `pref` are then all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R2) |
| wr_data | input | 32 | Register write data |
| lb_addr | input | 32 | Local-bus address to translate |
| hit | output | 1 | Some enabled window claims the address |
| win_idx | output | 2 | Index of the winning window |
| out_addr | output | 32 | Translated outbound address |
| cyc_type | output | 3 | Outbound cycle type code |
| pref | output | 1 | Winning window is prefetchable |

## Verification
Window arbitration and register update can meet in one cycle. The bench drives a write that enables a window in the same cycle that it presents an address inside that window. It checks that the output still shows the old miss before the clock edge and shows the new hit after it. Arbitration among overlapping windows is provoked by enlarging window 0 until it covers window 1. An address inside window 1 must then report window 0, with window 0's cycle type, prefetch flag and low-bit rule, rather than window 1's.

// File: rtl/awx_pkg.sv
package awx_pkg;
    localparam int ADDR_W   = 32;
    localparam int MAP_W    = 16;
    localparam int NUM_WIN  = 3;
    localparam int MEM_WIN  = 2;
    localparam int MIN_LOG2 = 20;
    localparam int MAX_CODE = 11;
    localparam int IO_LOG2  = 24;
    localparam int IDX_W    = $clog2(NUM_WIN);
    localparam int SEL_W    = $clog2(2 * NUM_WIN);

    localparam logic [2:0] CYC_IACK     = 3'd0;
    localparam logic [2:0] CYC_IO       = 3'd1;
    localparam logic [2:0] CYC_MEM      = 3'd3;
    localparam logic [2:0] CYC_CFG      = 3'd5;
    localparam logic [2:0] CYC_MEM_MULT = 3'd6;

    typedef struct packed {
        logic [NUM_WIN-1:0][ADDR_W-1:0] base;
        logic [NUM_WIN-1:0][MAP_W-1:0]  map;
    } awx_regs_t;
endpackage

// File: rtl/awx_regs.sv
module awx_regs
    import awx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output awx_regs_t        regs_q
);
    localparam int K_W = SEL_W - 1;

    awx_regs_t      regs_d;
    logic [K_W-1:0] slot;
    logic           is_map;

    assign slot   = wr_sel[SEL_W-1:1];
    assign is_map = wr_sel[0];

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (int'(slot) < NUM_WIN)) begin
            if (is_map)
                regs_d.map[slot] = wr_data[MAP_W-1:0];
            else
                regs_d.base[slot] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    assert_write_base0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=> (regs_q.base[0] == $past(wr_data)));

    assert_bad_sel_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_sel) >= 2 * NUM_WIN) |=> $stable(regs_q));
endmodule

// File: rtl/awx_mem_win.sv
module awx_mem_win
    import awx_pkg::*;
#(
    parameter int LOG2_MIN  = MIN_LOG2,
    parameter int CODE_MAX  = MAX_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [MAP_W-1:0]  map,
    output logic              match,
    output logic [ADDR_W-1:0] xaddr,
    output logic [2:0]        cyc,
    output logic              pf
);
    localparam int SH_W  = $clog2(ADDR_W) + 2;
    localparam int REP_W = ADDR_W - LOG2_MIN;

    logic [3:0]        code;
    logic              legal;
    logic [SH_W-1:0]   shamt;
    logic [ADDR_W-1:0] hi_mask;
    logic [ADDR_W-1:0] repl;
    logic [ADDR_W-1:0] mixed;

    assign code    = base[7:4];
    assign legal   = (int'(code) <= CODE_MAX);
    assign shamt   = SH_W'(LOG2_MIN) + SH_W'(code);
    assign hi_mask = {ADDR_W{1'b1}} << shamt;
    assign repl    = {map[MAP_W-1:MAP_W-REP_W], {LOG2_MIN{1'b0}}};

    always_comb begin
        match = base[0] && legal && (((addr ^ base) & hi_mask) == '0);
        mixed = (repl & hi_mask) | (addr & ~hi_mask);
        if (!map[0])
            mixed[1:0] = 2'b00;
        xaddr = mixed;
        cyc   = map[3:1];
        pf    = base[3];
    end

    assert_illegal_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(base[7:4]) > CODE_MAX) |-> !match);

    assert_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !base[0] |-> !match);
endmodule

// File: rtl/awx_io_win.sv
module awx_io_win
    import awx_pkg::*;
#(
    parameter int LOG2_IO = IO_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [MAP_W-1:0]  map,
    output logic              match,
    output logic [ADDR_W-1:0] xaddr,
    output logic [2:0]        cyc,
    output logic              pf
);
    localparam int TAG_W = ADDR_W - LOG2_IO;

    logic [TAG_W-1:0] tag;

    assign tag = base[MAP_W-1:MAP_W-TAG_W];

    always_comb begin
        match = base[0] && (addr[ADDR_W-1:LOG2_IO] == tag);
        xaddr = {map[MAP_W-1:MAP_W-TAG_W], addr[LOG2_IO-1:0]};
        cyc   = CYC_IO;
        pf    = 1'b0;
    end

    assert_io_low_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (xaddr[LOG2_IO-1:0] == addr[LOG2_IO-1:0]));
endmodule

// File: rtl/awx_prio.sv
module awx_prio
    import awx_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_WIN-1:0]             match,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] xaddr,
    input  logic [NUM_WIN-1:0][2:0]        cyc,
    input  logic [NUM_WIN-1:0]             pf,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx,
    output logic [ADDR_W-1:0]              addr_o,
    output logic [2:0]                     cyc_o,
    output logic                           pf_o
);
    always_comb begin
        hit    = 1'b0;
        idx    = '0;
        addr_o = '0;
        cyc_o  = '0;
        pf_o   = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit    = 1'b1;
                idx    = IDX_W'(i);
                addr_o = xaddr[i];
                cyc_o  = cyc[i];
                pf_o   = pf[i];
            end
        end
    end

    assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && idx != '0) |-> !match[0]);

    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (addr_o == '0 && cyc_o == '0 && !pf_o && idx == '0));
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
    import awx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [31:0]       lb_addr,
    output logic              hit,
    output logic [1:0]        win_idx,
    output logic [31:0]       out_addr,
    output logic [2:0]        cyc_type,
    output logic              pref
);
    awx_regs_t                      regs_q;
    logic [NUM_WIN-1:0]             w_match;
    logic [NUM_WIN-1:0][ADDR_W-1:0] w_xaddr;
    logic [NUM_WIN-1:0][2:0]        w_cyc;
    logic [NUM_WIN-1:0]             w_pf;

    awx_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        if (g < MEM_WIN) begin : g_mem
            awx_mem_win #(.LOG2_MIN(MIN_LOG2), .CODE_MAX(MAX_CODE)) u_mem (
                .clk   (clk),
                .rst_n (rst_n),
                .addr  (lb_addr),
                .base  (regs_q.base[g]),
                .map   (regs_q.map[g]),
                .match (w_match[g]),
                .xaddr (w_xaddr[g]),
                .cyc   (w_cyc[g]),
                .pf    (w_pf[g])
            );
        end else begin : g_io
            awx_io_win #(.LOG2_IO(IO_LOG2)) u_io (
                .clk   (clk),
                .rst_n (rst_n),
                .addr  (lb_addr),
                .base  (regs_q.base[g]),
                .map   (regs_q.map[g]),
                .match (w_match[g]),
                .xaddr (w_xaddr[g]),
                .cyc   (w_cyc[g]),
                .pf    (w_pf[g])
            );
        end
    end

    awx_prio u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .match  (w_match),
        .xaddr  (w_xaddr),
        .cyc    (w_cyc),
        .pf     (w_pf),
        .hit    (hit),
        .idx    (win_idx),
        .addr_o (out_addr),
        .cyc_o  (cyc_type),
        .pf_o   (pref)
    );

    assert_io_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && win_idx == 2'd2) |-> (cyc_type == CYC_IO && !pref));

    assert_low_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && win_idx == 2'd0 && !regs_q.map[0][0]) |-> (out_addr[1:0] == 2'b00));

    assert_mid_bits_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && win_idx < 2'd2) |-> (out_addr[MIN_LOG2-1:2] == lb_addr[MIN_LOG2-1:2]));

    assert_no_hit_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.base[0][0] == 1'b0 && regs_q.base[1][0] == 1'b0 && regs_q.base[2][0] == 1'b0)
        |-> !hit);
endmodule

// File: tb/addr_window_xlate_bench.sv
module addr_window_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] lb_addr = '0;
    logic        hit;
    logic [1:0]  win_idx;
    logic [31:0] out_addr;
    logic [2:0]  cyc_type;
    logic        pref;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    addr_window_xlate u_addr_window_xlate (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
        .wr_data (wr_data), .lb_addr (lb_addr), .hit (hit), .win_idx (win_idx),
        .out_addr (out_addr), .cyc_type (cyc_type), .pref (pref)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(string req, logic [31:0] a, logic eh, logic [1:0] ei,
                         logic [31:0] ea, logic [2:0] ec, logic ep);
        @(negedge clk);
        lb_addr = a;
        #1;
        chk(req, "hit", 32'(hit), 32'(eh));
        chk(req, "win_idx", 32'(win_idx), 32'(ei));
        chk(req, "out_addr", out_addr, ea);
        chk(req, "cyc_type", 32'(cyc_type), 32'(ec));
        chk(req, "pref", 32'(pref), 32'(ep));
    endtask

    // R1: nothing is enabled out of reset
    task automatic t_reset();
        probe("R1", 32'h4000_0000, 0, 0, 0, 0, 0);
        probe("R1", 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    endtask

    // R3 R5 R6 R7: 256 MB non-prefetch memory window, low bits forced
    task automatic t_win0();
        wr(3'd0, 32'h4000_0081);
        wr(3'd1, 32'h0000_8006);
        probe("R3_R5_R7", 32'h4123_4567, 1, 0, 32'h8123_4564, 3'd3, 0);
        probe("R3", 32'h3FFF_FFFF, 0, 0, 0, 0, 0);
    endtask

    // R6 R7: prefetchable window with low-bit pass-through
    task automatic t_win1();
        wr(3'd2, 32'h5000_0089);
        wr(3'd3, 32'h0000_9007);
        probe("R6_R7", 32'h5ABC_DEF3, 1, 1, 32'h9ABC_DEF3, 3'd3, 1);
    endtask

    // R9: window 0 enlarged to 512 MB covers window 1 and wins
    task automatic t_overlap();
        wr(3'd0, 32'h4000_0091);
        probe("R9", 32'h5ABC_DEF3, 1, 0, 32'h9ABC_DEF0, 3'd3, 0);
        wr(3'd0, 32'h4000_0081);
        probe("R9", 32'h5ABC_DEF3, 1, 1, 32'h9ABC_DEF3, 3'd3, 1);
    endtask

    // R8: fixed 16 MB I/O window
    task automatic t_io();
        wr(3'd4, 32'h0000_6001);
        wr(3'd5, 32'h0000_1200);
        probe("R8", 32'h60AB_CDEF, 1, 2, 32'h12AB_CDEF, 3'd1, 0);
        probe("R8", 32'h61AB_CDEF, 0, 0, 0, 0, 0);
    endtask

    // R4 R10: size code 12 never matches
    task automatic t_illegal();
        wr(3'd2, 32'h5000_00C9);
        probe("R4_R10", 32'h5000_1000, 0, 0, 0, 0, 0);
    endtask

    // R3 R5: smallest 1 MB window, configuration cycle type
    task automatic t_small();
        wr(3'd2, 32'h7010_0001);
        wr(3'd3, 32'h0000_ABCA);
        probe("R3_R5", 32'h701F_FFFF, 1, 1, 32'hABCF_FFFC, 3'd5, 0);
        probe("R3", 32'h7020_0000, 0, 0, 0, 0, 0);
        probe("R3", 32'h700F_FFFF, 0, 0, 0, 0, 0);
    endtask

    // R3 R5 R6: largest 2 GB window, memory read multiple
    task automatic t_large();
        wr(3'd0, 32'h8000_00B1);
        wr(3'd1, 32'h0000_000D);
        probe("R5_R6", 32'hF234_5677, 1, 0, 32'h7234_5677, 3'd6, 0);
        probe("R3", 32'h4123_4567, 0, 0, 0, 0, 0);
        probe("R9", 32'h701F_0000, 1, 1, 32'hABCF_0000, 3'd5, 0);
    endtask

    // R2: selects 6 and 7 leave every window unchanged
    task automatic t_ignored();
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        probe("R2", 32'hF234_5677, 1, 0, 32'h7234_5677, 3'd6, 0);
        probe("R2", 32'h6000_0000, 1, 2, 32'h1200_0000, 3'd1, 0);
        probe("R2", 32'h4000_0000, 0, 0, 0, 0, 0);
    endtask

    // R8: clearing the I/O enable removes the hit
    task automatic t_io_disable();
        wr(3'd4, 32'h0000_6000);
        probe("R8", 32'h60AB_CDEF, 0, 0, 0, 0, 0);
    endtask

    // R2: write and lookup in the same cycle
    task automatic t_write_timing();
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd4; wr_data = 32'h0000_6001;
        lb_addr = 32'h60AB_CDEF;
        #1;
        chk("R2", "hit before edge", 32'(hit), 32'd0);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        chk("R2", "hit after edge", 32'(hit), 32'd1);
        chk("R2", "out_addr after edge", out_addr, 32'h12AB_CDEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_win0();
        t_win1();
        t_overlap();
        t_io();
        t_illegal();
        t_small();
        t_large();
        t_ignored();
        t_io_disable();
        t_write_timing();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule